// File: doc/BRIEF.md
# Pairwise Edge Skew Detector

This block measures timing skew between three binary channel signals, each produced upstream by comparing one video channel against a programmable slice level (a 4-bit code chooses that level). The channels are compared in a ring: red against green, green against blue, and blue against red. For each pair the block finds which rising edge came first and how many clock cycles separate the two edges. It reports that distance as a signed pulse whose length in cycles equals the skew.

A measurement is accepted only when the two high periods overlap. The leading signal must still be high when the lagging signal rises, and the lag must not be longer than a configured maximum span. When the pair is confirmed, the block replays the measured distance as a run of consecutive "up" cycles if the first signal of the pair led, or "down" cycles if it lagged.

A saturating signed accumulator per pair integrates these pulses, so software or a control loop can read the net skew over many edges. Each accumulator has its own clear input.

Top module: `pair_skew_detector`

## Requirements
- R1: While reset is asserted, every pulse output is 00 and every accumulator reads 0.
- R2: Pair 0 compares red (first) with green (second), pair 1 compares green with blue, and pair 2 compares blue with red. Each pair's pulse port is {up, down}: bit 1 is up and bit 0 is down. Edges on one pair's signals produce no pulse on a pair that did not see both of its rising edges.
- R3: If the first signal rises k cycles before the second (1 <= k <= MAX_SPAN) and is still high when the second rises, up is high for exactly k consecutive cycles. These start in the cycle after the clock edge at which the second rise is sampled.
- R4: The mirror case, where the second signal leads by k cycles, produces a down pulse of exactly k cycles with the same timing.
- R5: Up and down of one pair are never high in the same cycle, and a pulse never switches sign from one cycle to the next.
- R6: If the leading signal falls at or before the edge at which the lagging signal rises, there is no overlap and no pulse is produced.
- R7: A lag larger than MAX_SPAN cycles produces no pulse.
- R8: Rising edges sampled at the same clock edge mean zero skew and produce no pulse.
- R9: Rising edges seen by a pair while its pulse is still being output are ignored. They start no new measurement.
- R10: An accumulator adds 1 for each cycle its pair's up is high and subtracts 1 for each down cycle. Each change is visible one cycle after the pulse cycle.
- R11: The accumulator saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1).
- R12: Clear bit i (bit 0 for red/green, bit 1 for green/blue, bit 2 for blue/red) sets that accumulator to 0 on the next edge. It takes priority over a pulse and leaves the other accumulators untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sliceR | input | 1 | Sliced red channel, synchronous to clk |
| sliceG | input | 1 | Sliced green channel, synchronous to clk |
| sliceB | input | 1 | Sliced blue channel, synchronous to clk |
| accClear | input | 3 | Per-pair accumulator clear (bit 0 R/G, bit 1 G/B, bit 2 B/R) |
| pulseRG | output | 2 | {up, down} for red with respect to green |
| pulseGB | output | 2 | {up, down} for green with respect to blue |
| pulseBR | output | 2 | {up, down} for blue with respect to red |
| accRG | output | ACC_W | Signed accumulated skew, red/green pair |
| accGB | output | ACC_W | Signed accumulated skew, green/blue pair |
| accBR | output | ACC_W | Signed accumulated skew, blue/red pair |

## Verification
The bench sweeps every pair and both lead directions over a range of lags. The range covers zero, every value from one up to the maximum span, and one past the maximum. Each lag is run once with overlapping high periods and once with the leader dropping exactly when the lagger rises. This separates an exact k-cycle pulse from an off-by-one length or start cycle, a swapped sign, a missing overlap check and a wrong span limit, and each run also checks that the two uninvolved pairs stay quiet. Dedicated patterns re-trigger a pair during its own pulse, drive an accumulator into both saturation limits, and clear one accumulator while the others hold values or while a pulse is active.

// File: rtl/skew_pkg.sv
package skew_pkg;

  localparam int NUM_PAIRS = 3;

  typedef enum logic [1:0] {
    PAIR_IDLE        = 2'd0,
    PAIR_LEAD_FIRST  = 2'd1,
    PAIR_LEAD_SECOND = 2'd2
  } pairState_t;

  // strobes from the control FSMs to the datapath, one set per pair
  typedef struct packed {
    logic load;    // start span count at 1
    logic step;    // span count + 1
    logic fire;    // copy span into replay counter
    logic fireUp;  // sign of the replayed pulse
  } pairStrobe_t;

endpackage

// File: rtl/skew_ctrl.sv
module skew_ctrl
  import skew_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PAIRS-1:0]         slices,
  input  logic [NUM_PAIRS-1:0]         spanFull,
  input  logic [NUM_PAIRS-1:0]         replayBusy,
  output pairStrobe_t [NUM_PAIRS-1:0]  strobe
);

  logic [NUM_PAIRS-1:0] prevSlices;
  logic [NUM_PAIRS-1:0] rises;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSlices <= '0;
    else       prevSlices <= slices;
  end

  assign rises = slices & ~prevSlices;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    localparam int PARTNER = (i + 1) % NUM_PAIRS;

    pairState_t  state, stateNext;
    pairStrobe_t st;
    logic firstLvl, secondLvl, firstRise, secondRise;

    assign firstLvl   = slices[i];
    assign secondLvl  = slices[PARTNER];
    assign firstRise  = rises[i];
    assign secondRise = rises[PARTNER];

    always_comb begin
      stateNext = state;
      st        = '0;
      unique case (state)
        PAIR_IDLE: begin
          if (!replayBusy[i]) begin
            if (firstRise && !secondLvl) begin
              stateNext = PAIR_LEAD_FIRST;
              st.load   = 1'b1;
            end else if (secondRise && !firstLvl) begin
              stateNext = PAIR_LEAD_SECOND;
              st.load   = 1'b1;
            end
          end
        end
        PAIR_LEAD_FIRST: begin
          if (!firstLvl) begin
            stateNext = PAIR_IDLE;            // leader dropped: no overlap
          end else if (secondLvl) begin
            stateNext = PAIR_IDLE;
            st.fire   = 1'b1;
            st.fireUp = 1'b1;
          end else if (spanFull[i]) begin
            stateNext = PAIR_IDLE;            // lag beyond range
          end else begin
            st.step = 1'b1;
          end
        end
        PAIR_LEAD_SECOND: begin
          if (!secondLvl) begin
            stateNext = PAIR_IDLE;
          end else if (firstLvl) begin
            stateNext = PAIR_IDLE;
            st.fire   = 1'b1;
            st.fireUp = 1'b0;
          end else if (spanFull[i]) begin
            stateNext = PAIR_IDLE;
          end else begin
            st.step = 1'b1;
          end
        end
        default: stateNext = PAIR_IDLE;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) state <= PAIR_IDLE;
      else       state <= stateNext;
    end

    assign strobe[i] = st;
  end

endmodule

// File: rtl/skew_datapath.sv
module skew_datapath
  import skew_pkg::*;
#(
  parameter int MAX_SPAN = 12,
  parameter int ACC_W    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pairStrobe_t [NUM_PAIRS-1:0]   strobe,
  input  logic [NUM_PAIRS-1:0]          accClear,
  output logic [NUM_PAIRS-1:0]          spanFull,
  output logic [NUM_PAIRS-1:0]          replayBusy,
  output logic [NUM_PAIRS-1:0]          pulseUp,
  output logic [NUM_PAIRS-1:0]          pulseDown,
  output logic [NUM_PAIRS*ACC_W-1:0]    accFlat
);

  localparam int SPAN_W = $clog2(MAX_SPAN + 1);
  localparam logic [SPAN_W-1:0] SPAN_LIMIT = SPAN_W'(MAX_SPAN);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_lane
    logic [SPAN_W-1:0]       span;
    logic [SPAN_W-1:0]       replayCnt;
    logic                    replaySign;
    logic signed [ACC_W-1:0] acc;
    logic                    busy, up, down;

    assign busy = (replayCnt != '0);
    assign up   = busy &  replaySign;
    assign down = busy & ~replaySign;

    // span counter: cycles since the leading rise
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               span <= '0;
      else if (strobe[i].load) span <= SPAN_W'(1);
      else if (strobe[i].step) span <= span + SPAN_W'(1);
    end

    // replay counter: emits the confirmed span as a pulse run
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        replayCnt  <= '0;
        replaySign <= 1'b0;
      end else if (strobe[i].fire) begin
        replayCnt  <= span;
        replaySign <= strobe[i].fireUp;
      end else if (busy) begin
        replayCnt  <= replayCnt - SPAN_W'(1);
      end
    end

    // saturating integrator
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      acc <= '0;
      else if (accClear[i])           acc <= '0;
      else if (up && acc != ACC_MAX)  acc <= acc + ACC_W'(1);
      else if (down && acc != ACC_MIN) acc <= acc - ACC_W'(1);
    end

    assign spanFull[i]   = (span == SPAN_LIMIT);
    assign replayBusy[i] = busy;
    assign pulseUp[i]    = up;
    assign pulseDown[i]  = down;
    assign accFlat[i*ACC_W +: ACC_W] = acc;
  end

endmodule

// File: rtl/pair_skew_detector.sv
module pair_skew_detector
  import skew_pkg::*;
#(
  parameter int MAX_SPAN = 12,
  parameter int ACC_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sliceR,
  input  logic             sliceG,
  input  logic             sliceB,
  input  logic [2:0]       accClear,
  output logic [1:0]       pulseRG,
  output logic [1:0]       pulseGB,
  output logic [1:0]       pulseBR,
  output logic [ACC_W-1:0] accRG,
  output logic [ACC_W-1:0] accGB,
  output logic [ACC_W-1:0] accBR
);

  pairStrobe_t [NUM_PAIRS-1:0] strobe;
  logic [NUM_PAIRS-1:0]        spanFull, replayBusy, pulseUp, pulseDown;
  logic [NUM_PAIRS*ACC_W-1:0]  accFlat;

  skew_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slices     ({sliceB, sliceG, sliceR}),
    .spanFull   (spanFull),
    .replayBusy (replayBusy),
    .strobe     (strobe)
  );

  skew_datapath #(.MAX_SPAN(MAX_SPAN), .ACC_W(ACC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .accClear   (accClear),
    .spanFull   (spanFull),
    .replayBusy (replayBusy),
    .pulseUp    (pulseUp),
    .pulseDown  (pulseDown),
    .accFlat    (accFlat)
  );

  assign pulseRG = {pulseUp[0], pulseDown[0]};
  assign pulseGB = {pulseUp[1], pulseDown[1]};
  assign pulseBR = {pulseUp[2], pulseDown[2]};
  assign accRG   = accFlat[0*ACC_W +: ACC_W];
  assign accGB   = accFlat[1*ACC_W +: ACC_W];
  assign accBR   = accFlat[2*ACC_W +: ACC_W];

endmodule

// File: rtl/pair_skew_detector_sva.sv
module pair_skew_detector_sva #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       accClear,
  input logic [1:0]       pulseRG,
  input logic [1:0]       pulseGB,
  input logic [1:0]       pulseBR,
  input logic [ACC_W-1:0] accRG,
  input logic [ACC_W-1:0] accGB,
  input logic [ACC_W-1:0] accBR
);

  localparam logic [ACC_W-1:0] TOP_VAL = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] BOT_VAL = {1'b1, {(ACC_W-1){1'b0}}};

  logic [1:0]       pl [3];
  logic [ACC_W-1:0] ac [3];

  assign pl[0] = pulseRG;
  assign pl[1] = pulseGB;
  assign pl[2] = pulseBR;
  assign ac[0] = accRG;
  assign ac[1] = accGB;
  assign ac[2] = accBR;

  // R1: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_quiet_r1: assert (pulseRG == 2'b00 && pulseGB == 2'b00 && pulseBR == 2'b00
                                && accRG == '0 && accGB == '0 && accBR == '0);
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_chk
    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
      !(pl[i][1] && pl[i][0]));

    p_no_flip_up_r5: assert property (@(posedge clk) disable iff (!rstN)
      pl[i][1] |=> !pl[i][0]);

    p_no_flip_down_r5: assert property (@(posedge clk) disable iff (!rstN)
      pl[i][0] |=> !pl[i][1]);

    p_acc_inc_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!accClear[i] && pl[i][1] && ac[i] != TOP_VAL) |=> ac[i] == ACC_W'($past(ac[i]) + 1));

    p_acc_dec_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!accClear[i] && pl[i][0] && ac[i] != BOT_VAL) |=> ac[i] == ACC_W'($past(ac[i]) - 1));

    p_acc_top_r11: assert property (@(posedge clk) disable iff (!rstN)
      (!accClear[i] && ac[i] == TOP_VAL && !pl[i][0]) |=> ac[i] == TOP_VAL);

    p_acc_bot_r11: assert property (@(posedge clk) disable iff (!rstN)
      (!accClear[i] && ac[i] == BOT_VAL && !pl[i][1]) |=> ac[i] == BOT_VAL);

    p_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
      accClear[i] |=> ac[i] == '0);
  end

endmodule

bind pair_skew_detector pair_skew_detector_sva #(.ACC_W(ACC_W)) u_sva (.*);

// File: tb/pair_skew_detector_test.sv
`timescale 1ns/1ps
module pair_skew_detector_test;

  localparam int MAXS = 6;
  localparam int AW   = 5;
  localparam int TOPV = (1 << (AW-1)) - 1;
  localparam int BOTV = -(1 << (AW-1));

  logic clk = 1'b0;
  logic rstN;
  logic sR, sG, sB;
  logic [2:0] clr;
  logic [1:0] pRG, pGB, pBR;
  logic [AW-1:0] aRG, aGB, aBR;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pair_skew_detector #(.MAX_SPAN(MAXS), .ACC_W(AW)) uut (
    .clk(clk), .rstN(rstN), .sliceR(sR), .sliceG(sG), .sliceB(sB),
    .accClear(clr), .pulseRG(pRG), .pulseGB(pGB), .pulseBR(pBR),
    .accRG(aRG), .accGB(aGB), .accBR(aBR)
  );

  function automatic logic [1:0] getPulse(int p);
    case (p)
      0: return pRG;
      1: return pGB;
      default: return pBR;
    endcase
  endfunction

  function automatic int getAcc(int p);
    case (p)
      0: return int'($signed(aRG));
      1: return int'($signed(aGB));
      default: return int'($signed(aBR));
    endcase
  endfunction

  function automatic int clampAcc(int v);
    if (v > TOPV) return TOPV;
    if (v < BOTV) return BOTV;
    return v;
  endfunction

  task automatic setSlice(int idx, bit v);
    case (idx)
      0: sR = v;
      1: sG = v;
      default: sB = v;
    endcase
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clearAll();
    @(negedge clk); clr = 3'b111;
    @(negedge clk); clr = 3'b000;
  endtask

  // one measurement on pair p; first signal leads if firstLeads
  task automatic sweepOne(int p, bit firstLeads, int k, int w, bit holdClr, int accBase);
    int ld, lg, n, bad, badAct, badExp, otherHits, accEarly, expEnd, expEarly;
    bit valid;
    string tag, accTag;
    ld = firstLeads ? p : (p + 1) % 3;
    lg = firstLeads ? (p + 1) % 3 : p;
    valid = (k >= 1) && (k <= MAXS) && (w > k);
    n = k + w + 2*MAXS + 6;
    bad = 0; badAct = 0; badExp = 0; otherHits = 0; accEarly = 0;
    if (valid) tag = firstLeads ? "R3" : "R4";
    else if (k == 0) tag = "R8";
    else if (k > MAXS) tag = "R7";
    else tag = "R6";
    for (int c = 0; c <= n; c++) begin
      @(negedge clk);
      begin
        logic [1:0] got, exp;
        bit act;
        act = valid && (c >= k + 1) && (c <= 2*k);
        exp = {act && firstLeads, act && !firstLeads};
        got = getPulse(p);
        if (got != exp && bad == 0) begin
          bad = c + 1; badAct = int'(got); badExp = int'(exp);
        end
        for (int q = 0; q < 3; q++)
          if (q != p && getPulse(q) != 2'b00) otherHits++;
        if (c == k + 2) accEarly = getAcc(p);
      end
      setSlice(ld, c < w);
      setSlice(lg, (c >= k) && (c < k + w));
      clr = holdClr ? 3'(1 << p) : 3'b000;
    end
    clr = 3'b000;
    check(bad == 0, tag, $sformatf("pulse pair %0d lead %0d lag %0d width %0d", p, firstLeads, k, w),
          badAct, badExp);
    check(otherHits == 0, "R2", $sformatf("other pairs quiet, pair %0d lag %0d", p, k), otherHits, 0);
    expEnd = holdClr ? 0 : clampAcc(accBase + (valid ? (firstLeads ? k : -k) : 0));
    if (holdClr) accTag = "R12";
    else if (valid && expEnd != accBase + (firstLeads ? k : -k)) accTag = "R11";
    else accTag = "R10";
    check(getAcc(p) == expEnd, accTag, $sformatf("acc pair %0d after lag %0d", p, k), getAcc(p), expEnd);
    if (valid) begin
      expEarly = holdClr ? 0 : clampAcc(accBase + (firstLeads ? 1 : -1));
      check(accEarly == expEarly, holdClr ? "R12" : "R10", "acc one cycle after first pulse cycle",
            accEarly, expEarly);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, upCnt, dnCnt;
    rstN = 1'b0; sR = 0; sG = 0; sB = 0; clr = 3'b000;
    repeat (3) @(negedge clk);
    check(pRG == 0 && pGB == 0 && pBR == 0, "R1", "pulses in reset",
          int'({pRG, pGB, pBR}), 0);
    check(aRG == 0 && aGB == 0 && aBR == 0, "R1", "accumulators in reset",
          int'({aRG, aGB, aBR}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // sweep: all pairs, both directions, lags 0..MAXS+1, overlap and no overlap
    for (int p = 0; p < 3; p++)
      for (int dir = 0; dir < 2; dir++)
        for (int k = 0; k <= MAXS + 1; k++) begin
          clearAll();
          sweepOne(p, dir == 1, k, k + 3, 1'b0, 0);
          clearAll();
          sweepOne(p, dir == 1, k, (k == 0) ? 3 : k, 1'b0, 0);
        end

    // R9: re-trigger on pair 2 (B leads R) while the first pulse is running
    clearAll();
    upCnt = 0; dnCnt = 0;
    for (int c = 0; c <= 30; c++) begin
      @(negedge clk);
      if (pBR[1]) upCnt++;
      if (pBR[0]) dnCnt++;
      sB = (c < 5) || (c >= 6 && c < 14);
      sR = (c >= 4 && c < 5) || (c >= 9 && c < 14);
    end
    check(upCnt == 4, "R9", "up cycles with rises during pulse", upCnt, 4);
    check(dnCnt == 0, "R9", "down cycles with rises during pulse", dnCnt, 0);
    check(getAcc(2) == 4, "R9", "acc after ignored rises", getAcc(2), 4);

    // R11: drive pair 1 into both limits
    clearAll();
    base = 0;
    for (int r = 0; r < 3; r++) begin
      sweepOne(1, 1'b1, MAXS, MAXS + 3, 1'b0, base);
      base = clampAcc(base + MAXS);
    end
    check(getAcc(1) == TOPV, "R11", "upper limit", getAcc(1), TOPV);
    for (int r = 0; r < 6; r++) begin
      sweepOne(1, 1'b0, MAXS, MAXS + 3, 1'b0, base);
      base = clampAcc(base - MAXS);
    end
    check(getAcc(1) == BOTV, "R11", "lower limit", getAcc(1), BOTV);

    // R12: selective clear, then clear held during a pulse
    clearAll();
    sweepOne(0, 1'b1, 2, 5, 1'b0, 0);
    sweepOne(1, 1'b0, 3, 6, 1'b0, 0);
    @(negedge clk); clr = 3'b010;
    @(negedge clk); clr = 3'b000;
    @(negedge clk);
    check(getAcc(1) == 0, "R12", "cleared pair", getAcc(1), 0);
    check(getAcc(0) == 2, "R12", "untouched pair", getAcc(0), 2);
    sweepOne(2, 1'b1, 5, 8, 1'b1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule